// File: doc/BRIEF.md
# Exception Vector Window Remapper

This block sits between the processor's fetch and load path and the memory decoders. It watches every bus address. The lowest 64 bytes of the address space form a remap window: 32 bytes of exception vectors, then 32 bytes of literal constants that long-range jumps use. Any address inside this window is redirected to the matching offset in one backing region. A small mapping-control register picks the region: the boot block, user flash or RAM. Every other address goes through untouched. The output is the translated address together with a code that names the region it falls in. The memory decoders use these two outputs to steer the access.

Translation is purely combinational. The window is an alias and nothing is copied, so the region's own home address can still be read while the window points at it. The boot block sits at the very top of the address space, so its location does not depend on how much flash a device has. The mapping register resets to the boot block, so the first fetch from address zero after reset always runs boot code.

Top module: `vector_remap_ctrl`

## Requirements
- R1: After reset, with no write to the mapping register, an access at address 0 is translated to the boot block base address, and the region code is 3.
- R2: With mapping mode 0, a window address A (below 0x40) becomes BOOT_BASE + A, and the region code is 3 (boot). BOOT_BASE is 2^ADDR_W - BOOT_BYTES.
- R3: With mapping mode 1, a window address A stays A, and the region code is 1 (flash).
- R4: With mapping mode 2, a window address A becomes RAM_BASE + A, and the region code is 2 (RAM).
- R5: Mapping mode 3 is reserved and behaves exactly like mode 0.
- R6: An address of 0x40 or above is never changed, whatever the mapping mode.
- R7: A byte read through the window at offset k equals the byte read at the selected region's home address plus k.
- R8: A write to the mapping register with map_wr_en high is captured on the next rising clock edge. The translation changes only from that edge on. While map_wr_en is low, the mapping is left as it is.
- R9: A translated address that falls in none of the regions gets region code 0. The regions are flash at [0, FLASH_BYTES), RAM at [RAM_BASE, RAM_BASE+RAM_BYTES) and boot at [BOOT_BASE, 2^ADDR_W).
- R10: Address 0x3F is the last address that is remapped. Address 0x40 is the first that passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_wr_en | input | 1 | Write strobe for the mapping register |
| map_wr_mode | input | 2 | New mapping mode: 0 boot, 1 flash, 2 RAM, 3 reserved (boot) |
| bus_addr_i | input | ADDR_W | Address from the bus master |
| mem_region_o | output | 2 | Region code: 0 none, 1 flash, 2 RAM, 3 boot |
| mem_addr_o | output | ADDR_W | Translated address |

## Verification
The bench builds the block with a 16-bit address, 4 kB of flash, 2 kB of RAM at 0x8000 and a 12 kB boot block at 0xD000. With these values every region edge and every unmapped gap can be reached with a few directed addresses. Each backing region is modelled as a byte pattern computed from the address. This lets the bench compare a window read with a home-address read under every mapping mode. The timing of a mapping change is probed on both sides of the capturing edge.

// File: rtl/vremap_pkg.sv
// Shared types for the vector window remapper.
// Assumes: encodings below are fixed; the decoders downstream rely on them.
package vremap_pkg;
    typedef enum logic [1:0] {
        MAP_BOOT  = 2'd0,
        MAP_FLASH = 2'd1,
        MAP_RAM   = 2'd2,
        MAP_RSVD  = 2'd3
    } map_mode_e;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_FLASH = 2'd1,
        RGN_RAM   = 2'd2,
        RGN_BOOT  = 2'd3
    } region_e;
endpackage

// File: rtl/vremap_mode_reg.sv
// Mapping-control register. Holds the mode that selects the window source.
// Assumes: synchronous active-low reset; the reset value selects the boot block.
module vremap_mode_reg
    import vremap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic [1:0] wr_mode,
    output map_mode_e mode_o
);
    map_mode_e mode_q;

    // Capture a new mode on a write strobe; fall back to boot on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MAP_BOOT;
        else if (wr_en)
            mode_q <= map_mode_e'(wr_mode);
    end

    assign mode_o = mode_q;

    assert_reset_boot_R1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == MAP_BOOT));

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_q == map_mode_e'($past(wr_mode))));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> $stable(mode_q));
endmodule

// File: rtl/vremap_xlate.sv
// Window translator. It replaces an address inside the low window with the
// same offset in the selected region and passes every other address through.
// Assumes: WIN_BYTES is a power of two; the region bases are aligned to WIN_BYTES.
module vremap_xlate
    import vremap_pkg::*;
#(
    parameter int unsigned            ADDR_W    = 32,
    parameter int unsigned            WIN_BYTES = 64,
    parameter logic [ADDR_W-1:0]      RAM_BASE  = '0,
    parameter logic [ADDR_W-1:0]      BOOT_BASE = '0
) (
    input  map_mode_e         mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              in_win_o
);
    localparam int unsigned WIN_AW = $clog2(WIN_BYTES);

    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] win_off;

    // Detect the window: all address bits above the offset field are zero.
    assign in_win_o = (addr_i[ADDR_W-1:WIN_AW] == '0);
    assign win_off  = {{(ADDR_W-WIN_AW){1'b0}}, addr_i[WIN_AW-1:0]};

    // Pick the base of the region that supplies the window.
    always_comb begin
        unique case (mode_i)
            MAP_FLASH: base_sel = '0;
            MAP_RAM:   base_sel = RAM_BASE;
            default:   base_sel = BOOT_BASE;
        endcase
    end

    // Form the outgoing address.
    assign addr_o = in_win_o ? (base_sel | win_off) : addr_i;
endmodule

// File: rtl/vremap_rgn_decode.sv
// Region decoder. It names the backing region that a translated address falls in.
// Assumes: the regions do not overlap; the boot block runs to the top of the space.
module vremap_rgn_decode
    import vremap_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       FLASH_BYTES = 32768,
    parameter logic [ADDR_W-1:0] RAM_BASE    = '0,
    parameter int unsigned       RAM_BYTES   = 8192,
    parameter logic [ADDR_W-1:0] BOOT_BASE   = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o
);
    localparam int NRGN = 3;
    localparam logic [ADDR_W:0] LO [NRGN] = '{
        (ADDR_W+1)'(0),
        {1'b0, RAM_BASE},
        {1'b0, BOOT_BASE}};
    localparam logic [ADDR_W:0] HI [NRGN] = '{
        (ADDR_W+1)'(FLASH_BYTES),
        {1'b0, RAM_BASE} + (ADDR_W+1)'(RAM_BYTES),
        {1'b1, {ADDR_W{1'b0}}}};

    logic [NRGN-1:0] hit;
    logic [ADDR_W:0] a_ext;

    assign a_ext = {1'b0, addr_i};

    // One range comparator per region.
    for (genvar g = 0; g < NRGN; g++) begin : g_rng
        assign hit[g] = (a_ext >= LO[g]) && (a_ext < HI[g]);
    end

    // Convert the hit vector to the region code.
    always_comb begin
        if (hit[2])      region_o = RGN_BOOT;
        else if (hit[1]) region_o = RGN_RAM;
        else if (hit[0]) region_o = RGN_FLASH;
        else             region_o = RGN_NONE;
    end
endmodule

// File: rtl/vector_remap_ctrl.sv
// Top of the vector window remapper. It aliases the lowest WIN_BYTES of the
// address space onto the boot block, user flash or RAM and reports the region.
// Assumes: combinational path from bus_addr_i to the outputs; mode changes apply
// from the clock edge that captures the write.
module vector_remap_ctrl
    import vremap_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned WIN_BYTES   = 64,
    parameter int unsigned FLASH_BYTES = 32768,
    parameter int unsigned RAM_BYTES   = 8192,
    parameter longint      RAM_BASE_L  = 64'h4000_0000,
    parameter int unsigned BOOT_BYTES  = 12288
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_wr_en,
    input  logic [1:0]        map_wr_mode,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output logic [1:0]        mem_region_o,
    output logic [ADDR_W-1:0] mem_addr_o
);
    localparam logic [ADDR_W-1:0] RAM_BASE  = ADDR_W'(RAM_BASE_L);
    localparam logic [ADDR_W-1:0] BOOT_BASE =
        ADDR_W'((64'd1 << ADDR_W) - 64'(BOOT_BYTES));
    localparam int unsigned WIN_AW = $clog2(WIN_BYTES);

    map_mode_e mode;
    logic      in_win;
    region_e   region;

    vremap_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (map_wr_en),
        .wr_mode (map_wr_mode),
        .mode_o  (mode)
    );

    vremap_xlate #(
        .ADDR_W    (ADDR_W),
        .WIN_BYTES (WIN_BYTES),
        .RAM_BASE  (RAM_BASE),
        .BOOT_BASE (BOOT_BASE)
    ) u_xlate (
        .mode_i   (mode),
        .addr_i   (bus_addr_i),
        .addr_o   (mem_addr_o),
        .in_win_o (in_win)
    );

    vremap_rgn_decode #(
        .ADDR_W      (ADDR_W),
        .FLASH_BYTES (FLASH_BYTES),
        .RAM_BASE    (RAM_BASE),
        .RAM_BYTES   (RAM_BYTES),
        .BOOT_BASE   (BOOT_BASE)
    ) u_dec (
        .addr_i   (mem_addr_o),
        .region_o (region)
    );

    assign mem_region_o = region;

    assert_pass_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_win |-> (mem_addr_o == bus_addr_i));

    assert_keep_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> (mem_addr_o[WIN_AW-1:0] == bus_addr_i[WIN_AW-1:0]));

    assert_flash_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && mode == MAP_FLASH) |-> (region == RGN_FLASH));

    assert_boot_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && (mode == MAP_BOOT || mode == MAP_RSVD)) |-> (region == RGN_BOOT));

    assert_ram_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && mode == MAP_RAM) |-> (region == RGN_RAM));
endmodule

// File: tb/vector_remap_ctrl_tb.sv
// Directed bench for the vector window remapper.
module vector_remap_ctrl_tb_top;
    localparam int unsigned AW   = 16;
    localparam logic [15:0] RAMB = 16'h8000;
    localparam logic [15:0] BOOTB = 16'hD000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_wr_en = 1'b0;
    logic [1:0]  map_wr_mode = 2'd0;
    logic [15:0] bus_addr_i = 16'h0;
    logic [1:0]  mem_region_o;
    logic [15:0] mem_addr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vector_remap_ctrl #(
        .ADDR_W      (AW),
        .WIN_BYTES   (64),
        .FLASH_BYTES (4096),
        .RAM_BYTES   (2048),
        .RAM_BASE_L  (64'h8000),
        .BOOT_BYTES  (12288)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .map_wr_en    (map_wr_en),
        .map_wr_mode  (map_wr_mode),
        .bus_addr_i   (bus_addr_i),
        .mem_region_o (mem_region_o),
        .mem_addr_o   (mem_addr_o)
    );

    // Byte content model of each backing region, indexed by home address.
    function automatic logic [7:0] mem_byte(input logic [1:0] rgn, input logic [15:0] a);
        case (rgn)
            2'd1:    return a[7:0] + 8'h11;
            2'd2:    return ~a[7:0];
            2'd3:    return a[7:0] ^ 8'h5A ^ a[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(input logic [15:0] a);
        @(negedge clk);
        bus_addr_i = a;
        #2;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        map_wr_en = 1'b1;
        map_wr_mode = m;
        @(negedge clk);
        map_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        probe(16'h0000);
        chk("R1 addr", 32'(mem_addr_o), 32'(BOOTB));
        chk("R1 region", 32'(mem_region_o), 32'd3);
    endtask

    task automatic t_boot;
        set_mode(2'd0);
        probe(16'h0014);
        chk("R2 addr", 32'(mem_addr_o), 32'(BOOTB + 16'h14));
        chk("R2 region", 32'(mem_region_o), 32'd3);
    endtask

    task automatic t_flash;
        set_mode(2'd1);
        probe(16'h0021);
        chk("R3 addr", 32'(mem_addr_o), 32'h21);
        chk("R3 region", 32'(mem_region_o), 32'd1);
    endtask

    task automatic t_ram;
        set_mode(2'd2);
        probe(16'h0008);
        chk("R4 addr", 32'(mem_addr_o), 32'(RAMB + 16'h8));
        chk("R4 region", 32'(mem_region_o), 32'd2);
    endtask

    task automatic t_rsvd;
        set_mode(2'd3);
        probe(16'h003C);
        chk("R5 addr", 32'(mem_addr_o), 32'(BOOTB + 16'h3C));
        chk("R5 region", 32'(mem_region_o), 32'd3);
    endtask

    task automatic t_pass;
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            probe(16'h0100);
            chk("R6 flash addr", 32'(mem_addr_o), 32'h0100);
            chk("R6 flash rgn", 32'(mem_region_o), 32'd1);
            probe(16'h8010);
            chk("R6 ram addr", 32'(mem_addr_o), 32'h8010);
            chk("R6 ram rgn", 32'(mem_region_o), 32'd2);
        end
        probe(16'hFFFF);
        chk("R9 top boot", 32'(mem_region_o), 32'd3);
        probe(16'h1000);
        chk("R9 flash end", 32'(mem_region_o), 32'd0);
        probe(16'h8800);
        chk("R9 ram end", 32'(mem_region_o), 32'd0);
        probe(16'hCFFF);
        chk("R9 below boot", 32'(mem_region_o), 32'd0);
    endtask

    task automatic t_alias;
        logic [7:0] via_win;
        logic [15:0] home [3] = '{BOOTB, 16'h0000, RAMB};
        logic [1:0]  rg   [3] = '{2'd3, 2'd1, 2'd2};
        for (int m = 0; m < 3; m++) begin
            set_mode(2'(m));
            for (int k = 0; k < 64; k += 21) begin
                probe(16'(k));
                via_win = mem_byte(mem_region_o, mem_addr_o);
                probe(home[m] + 16'(k));
                chk("R7 alias data", 32'(via_win), 32'(mem_byte(rg[m], home[m] + 16'(k))));
                chk("R7 home data", 32'(mem_byte(mem_region_o, mem_addr_o)),
                    32'(mem_byte(rg[m], home[m] + 16'(k))));
            end
        end
    endtask

    task automatic t_timing;
        set_mode(2'd1);
        probe(16'h0004);
        map_wr_en = 1'b1;
        map_wr_mode = 2'd2;
        #2;
        chk("R8 before edge", 32'(mem_addr_o), 32'h0004);
        @(posedge clk);
        #2;
        chk("R8 after edge", 32'(mem_addr_o), 32'(RAMB + 16'h4));
        @(negedge clk);
        map_wr_en = 1'b0;
        map_wr_mode = 2'd0;
        repeat (3) @(posedge clk);
        #2;
        chk("R8 hold idle", 32'(mem_addr_o), 32'(RAMB + 16'h4));
    endtask

    task automatic t_edge;
        set_mode(2'd2);
        probe(16'h003F);
        chk("R10 last in", 32'(mem_addr_o), 32'(RAMB + 16'h3F));
        probe(16'h0040);
        chk("R10 first out", 32'(mem_addr_o), 32'h0040);
        chk("R10 first out rgn", 32'(mem_region_o), 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_boot();
        t_flash();
        t_ram();
        t_rsvd();
        t_pass();
        t_alias();
        t_timing();
        t_edge();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule